// File: doc/BRIEF.md
# Single-Pass Streaming Softmax Attention Unit

This block computes decode-time attention for one head. A query vector is loaded once. Key/value pairs then stream in one at a time, in token order. Each pair is read exactly once. The dot product with the query is formed over several cycles on a small set of parallel multiply lanes. The score is then folded into three running quantities: the largest score seen so far, a normalizer that sums exponentials relative to that maximum, and a weighted value accumulator.

When a larger score arrives, the old normalizer and accumulator are scaled down before the new token is added, so no term ever exceeds one. Exponentials use a 16-entry table of fractional powers of two together with a right shift. No score vector is ever stored.

A token flagged as final closes the sequence. Each accumulator element is then divided by the normalizer in its own sequential restoring divider. The result vector is offered with valid/ready. Loading a new query at any time discards all running state.

Top module: `attn_stream`

## Requirements
- R1: After reset, `kv_ready` and `out_valid` are both low.
- R2: `kv_ready` stays low until a query has been loaded. In the cycle after a `q_load` pulse, `kv_ready` is high.
- R3: With `kv_valid` held high, successive key/value pairs are accepted exactly 4 clock cycles apart (16 elements on 4 lanes).
- R4: A sequence of one token yields an output vector exactly equal to that token's value vector.
- R5: For signed query, key and value data with rising scores, where each token sets a new maximum, every output element is within 32 LSB of the exact softmax-weighted sum of the values. All vectors are 16 elements of signed Q8.8 packed with element 0 in the low bits, and the score is the Q8.8 dot product.
- R6: For falling scores, where the first token holds the maximum, outputs are within 32 LSB of exact softmax attention.
- R7: Tokens with equal scores get equal weights, so the output is within 1 LSB of the plain average of their values.
- R8: A token whose score is 100 below the maximum contributes nothing. This holds whether it arrives before the dominant token (rescaled to zero) or after it, so the output equals the dominant value vector exactly.
- R9: After a token with `kv_last` is accepted, `kv_ready` stays low until the next query load. Pairs offered in that time do not change the output.
- R10: A `q_load` in the middle of a sequence discards all earlier tokens. The next output depends only on tokens sent after the load.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vec` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_load | input | 1 | Load query and clear running state |
| q_vec | input | 256 | Query vector, 16 x Q8.8 |
| kv_valid | input | 1 | Key/value pair offered |
| kv_ready | output | 1 | Pair accepted this cycle when valid |
| kv_last | input | 1 | Offered pair is the final token |
| k_vec | input | 256 | Key vector, 16 x Q8.8 |
| v_vec | input | 256 | Value vector, 16 x Q8.8 |
| out_valid | output | 1 | Result vector available |
| out_ready | input | 1 | Consumer takes the result |
| out_vec | output | 256 | Attention output, 16 x Q8.8 |

## Verification
The bench targets the rescale path, with a new maximum on every token, and the no-rescale path, with a fixed maximum, separately. A swapped scale factor in either path pulls the result far from the softmax reference. Equal scores catch a table entry for zero that is not exactly one. The 100-unit score gap, tested in both arrival orders, catches a shift that fails to saturate to zero. A clamped or mis-sized shift would leak a stale value into the output. Tokens offered after the last one, and a query reload in mid-sequence, expose a design that keeps accepting or keeps stale accumulator contents. The interval between accepts shows whether the key fetch overlaps the dot product or adds a stall.

// File: rtl/attn_pkg.sv
package attn_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RUN   = 3'd1,
        PH_DRAIN = 3'd2,
        PH_PREP  = 3'd3,
        PH_DIV   = 3'd4,
        PH_OUT   = 3'd5
    } phase_e;

    // log2(e) in Q.16
    localparam int unsigned LOG2E_Q16 = 94548;

    // 2^(-f/16) in Q.16, f = 0..15
    function automatic logic [16:0] exp2_frac(input logic [3:0] f);
        case (f)
            4'd0:  return 17'd65536;
            4'd1:  return 17'd62757;
            4'd2:  return 17'd60097;
            4'd3:  return 17'd57549;
            4'd4:  return 17'd55109;
            4'd5:  return 17'd52773;
            4'd6:  return 17'd50535;
            4'd7:  return 17'd48393;
            4'd8:  return 17'd46341;
            4'd9:  return 17'd44376;
            4'd10: return 17'd42495;
            4'd11: return 17'd40693;
            4'd12: return 17'd38968;
            4'd13: return 17'd37315;
            4'd14: return 17'd35734;
            default: return 17'd34219;
        endcase
    endfunction

endpackage

// File: rtl/attn_exp.sv
// Weight = 2^(-diff*log2 e): integer part as shift, top 4 fraction bits index the table.
module attn_exp #(
    parameter int D_W  = 32,
    parameter int FRAC = 16
) (
    input  logic [D_W-1:0]  diff,
    output logic [FRAC:0]   weight
);
    import attn_pkg::*;
    localparam int PW = D_W + 17;
    localparam int NW = PW - 2*FRAC;

    logic [PW-1:0] prod;
    logic [NW-1:0] n_int;
    logic [3:0]    f_idx;
    logic          unused_lo;

    assign prod      = PW'(diff) * PW'(LOG2E_Q16);
    assign n_int     = prod[PW-1:2*FRAC];
    assign f_idx     = prod[2*FRAC-1:2*FRAC-4];
    assign unused_lo = ^prod[2*FRAC-5:0];

    always_comb begin
        if (n_int >= NW'(FRAC + 1)) weight = '0;
        else                        weight = exp2_frac(f_idx) >> n_int;
    end
endmodule

// File: rtl/attn_dot_lanes.sv
// One slice of the dot product: LANES products reduced in a single cycle.
module attn_dot_lanes #(
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int SW    = 32
) (
    input  logic [LANES-1:0][DW-1:0] q_part,
    input  logic [LANES-1:0][DW-1:0] k_part,
    output logic signed [SW-1:0]     partial
);
    always_comb begin
        partial = '0;
        for (int i = 0; i < LANES; i++) begin
            partial = partial + SW'($signed(q_part[i])) * SW'($signed(k_part[i]));
        end
    end
endmodule

// File: rtl/attn_div.sv
// Sequential restoring divider, sign-magnitude, saturating output.
module attn_div #(
    parameter int NUM_W = 40,
    parameter int DEN_W = 32,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic [NUM_W-1:0]        num,
    input  logic                    neg,
    input  logic [DEN_W-1:0]        den,
    output logic                    done,
    output logic signed [OUT_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             neg;
        logic [CNT_W-1:0] cnt;
        logic [DEN_W:0]   rem;
        logic [NUM_W-1:0] nq;
        logic [DEN_W-1:0] den;
    } dv_t;

    dv_t s_q, s_d;
    logic [DEN_W:0]   trial;
    logic [OUT_W-1:0] sat;

    always_comb begin
        s_d   = s_q;
        trial = {s_q.rem[DEN_W-1:0], s_q.nq[NUM_W-1]};
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
            s_d.cnt  = '0;
            s_d.rem  = '0;
            s_d.nq   = num;
            s_d.den  = den;
            s_d.neg  = neg;
        end else if (s_q.busy) begin
            if (trial >= {1'b0, s_q.den}) begin
                s_d.rem = trial - {1'b0, s_q.den};
                s_d.nq  = {s_q.nq[NUM_W-2:0], 1'b1};
            end else begin
                s_d.rem = trial;
                s_d.nq  = {s_q.nq[NUM_W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_W'(NUM_W - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (|s_q.nq[NUM_W-1:OUT_W-1]) sat = {1'b0, {(OUT_W-1){1'b1}}};
        else                          sat = s_q.nq[OUT_W-1:0];
        quo = s_q.neg ? -$signed(sat) : $signed(sat);
    end

    assign done = s_q.done;
endmodule

// File: rtl/attn_stream.sv
module attn_stream #(
    parameter int DIM   = 16,
    parameter int LANES = 4,
    parameter int DW    = 16,
    parameter int SW    = 32,
    parameter int FRAC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_load,
    input  logic [DIM*DW-1:0] q_vec,
    input  logic              kv_valid,
    output logic              kv_ready,
    input  logic              kv_last,
    input  logic [DIM*DW-1:0] k_vec,
    input  logic [DIM*DW-1:0] v_vec,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DIM*DW-1:0] out_vec
);
    import attn_pkg::*;

    localparam int CHUNKS = DIM / LANES;
    localparam int CW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
    localparam int EW     = FRAC + 1;
    localparam int VFRAC  = DW / 2;
    localparam int PW     = SW + EW + 1;
    localparam int NUM_W  = SW + VFRAC;
    localparam logic [EW-1:0] ONE = EW'(1) << FRAC;

    typedef struct packed {
        phase_e                     phase;
        logic                       first;
        logic                       a_busy;
        logic [CW-1:0]              chunk;
        logic [DIM-1:0][DW-1:0]     q;
        logic [DIM-1:0][DW-1:0]     k;
        logic [DIM-1:0][DW-1:0]     v;
        logic signed [SW-1:0]       dot;
        logic                       a_first;
        logic                       a_last;
        logic                       b_valid;
        logic                       b_first;
        logic                       b_last;
        logic signed [SW-1:0]       b_score;
        logic [DIM-1:0][DW-1:0]     b_v;
        logic signed [SW-1:0]       m;
        logic [SW-1:0]              l;
        logic [DIM-1:0][SW-1:0]     acc;
    } st_t;

    st_t s_q, s_d;

    logic [LANES-1:0][DW-1:0] q_part, k_part;
    logic signed [SW-1:0]     partial, score;
    logic                     fire, new_max;
    logic [SW-1:0]            diff;
    logic [EW-1:0]            e_w, sc_a, sc_b;
    logic [DIM-1:0]           div_done;
    logic [DIM-1:0][DW-1:0]   div_quo;

    assign kv_ready = (s_q.phase == PH_RUN) && (!s_q.a_busy || s_q.chunk == CW'(CHUNKS - 1));
    assign fire     = kv_valid && kv_ready;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            q_part[i] = s_q.q[int'(s_q.chunk) * LANES + i];
            k_part[i] = s_q.k[int'(s_q.chunk) * LANES + i];
        end
    end

    attn_dot_lanes #(.LANES(LANES), .DW(DW), .SW(SW)) u_dot (
        .q_part (q_part),
        .k_part (k_part),
        .partial(partial)
    );
    assign score = s_q.dot + partial;

    assign new_max = s_q.b_score > s_q.m;
    assign diff    = new_max ? SW'(s_q.b_score - s_q.m) : SW'(s_q.m - s_q.b_score);

    attn_exp #(.D_W(SW), .FRAC(FRAC)) u_exp (
        .diff  (diff),
        .weight(e_w)
    );
    assign sc_a = new_max ? e_w : ONE;
    assign sc_b = new_max ? ONE : e_w;

    always_comb begin
        logic signed [PW-1:0] pa, pv;
        logic [PW-1:0]        pl;
        s_d = s_q;
        s_d.b_valid = 1'b0;

        if (s_q.a_busy) begin
            if (s_q.chunk != CW'(CHUNKS - 1)) begin
                s_d.dot   = score;
                s_d.chunk = s_q.chunk + 1'b1;
            end else begin
                s_d.b_valid = 1'b1;
                s_d.b_score = score;
                s_d.b_v     = s_q.v;
                s_d.b_first = s_q.a_first;
                s_d.b_last  = s_q.a_last;
                s_d.a_busy  = 1'b0;
            end
        end

        if (fire) begin
            s_d.a_busy  = 1'b1;
            s_d.chunk   = '0;
            s_d.dot     = '0;
            s_d.k       = k_vec;
            s_d.v       = v_vec;
            s_d.a_first = s_q.first;
            s_d.a_last  = kv_last;
            s_d.first   = 1'b0;
            if (kv_last) s_d.phase = PH_DRAIN;
        end

        if (s_q.b_valid) begin
            if (s_q.b_first) begin
                s_d.m = s_q.b_score;
                s_d.l = SW'(ONE);
                for (int j = 0; j < DIM; j++)
                    s_d.acc[j] = SW'($signed(s_q.b_v[j])) <<< (FRAC - VFRAC);
            end else begin
                if (new_max) s_d.m = s_q.b_score;
                pl    = PW'(s_q.l) * PW'(sc_a);
                s_d.l = SW'(pl >> FRAC) + SW'(sc_b);
                for (int j = 0; j < DIM; j++) begin
                    pa = PW'($signed(s_q.acc[j])) * PW'($signed({1'b0, sc_a}));
                    pv = PW'($signed(s_q.b_v[j])) * PW'($signed({1'b0, sc_b}));
                    s_d.acc[j] = SW'(pa >>> FRAC) + SW'(pv >>> VFRAC);
                end
            end
            if (s_q.b_last) s_d.phase = PH_PREP;
        end

        case (s_q.phase)
            PH_PREP: s_d.phase = PH_DIV;
            PH_DIV:  if (&div_done) s_d.phase = PH_OUT;
            PH_OUT:  if (out_ready) s_d.phase = PH_IDLE;
            default: ;
        endcase

        if (q_load) begin
            s_d.phase   = PH_RUN;
            s_d.q       = q_vec;
            s_d.first   = 1'b1;
            s_d.a_busy  = 1'b0;
            s_d.b_valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < DIM; g++) begin : g_div
        logic [SW-1:0] mag;
        assign mag = s_q.acc[g][SW-1] ? SW'(-$signed(s_q.acc[g])) : s_q.acc[g];
        attn_div #(.NUM_W(NUM_W), .DEN_W(SW), .OUT_W(DW)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .start(s_q.phase == PH_PREP),
            .abort(q_load),
            .num  ({mag, {VFRAC{1'b0}}}),
            .neg  (s_q.acc[g][SW-1]),
            .den  (s_q.l),
            .done (div_done[g]),
            .quo  (div_quo[g])
        );
    end

    assign out_valid = (s_q.phase == PH_OUT);
    assign out_vec   = div_quo;
endmodule

// File: rtl/attn_stream_chk.sv
module attn_stream_chk #(
    parameter int DIM = 16,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              q_load,
    input logic              kv_valid,
    input logic              kv_ready,
    input logic              kv_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DIM*DW-1:0] out_vec
);
    assert_accept_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kv_valid && kv_ready && !q_load) |=> !kv_ready);

    assert_last_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (kv_valid && kv_ready && kv_last && !q_load) |=> !kv_ready);

    assert_ready_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_load |=> kv_ready);

    assert_load_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_load |=> !out_valid);

    assert_output_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !q_load) |=> (out_valid && $stable(out_vec)));
endmodule

bind attn_stream attn_stream_chk #(.DIM(DIM), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_load   (q_load),
    .kv_valid (kv_valid),
    .kv_ready (kv_ready),
    .kv_last  (kv_last),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_vec  (out_vec)
);

// File: tb/attn_stream_bench.sv
module attn_stream_bench;
    localparam int DIM = 16;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              q_load = 1'b0;
    logic [DIM*DW-1:0] q_vec = '0;
    logic              kv_valid = 1'b0;
    logic              kv_ready;
    logic              kv_last = 1'b0;
    logic [DIM*DW-1:0] k_vec = '0;
    logic [DIM*DW-1:0] v_vec = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DIM*DW-1:0] out_vec;

    always #4 clk = ~clk;

    attn_stream u_attn_stream (
        .clk(clk), .rst_n(rst_n), .q_load(q_load), .q_vec(q_vec),
        .kv_valid(kv_valid), .kv_ready(kv_ready), .kv_last(kv_last),
        .k_vec(k_vec), .v_vec(v_vec), .out_valid(out_valid),
        .out_ready(out_ready), .out_vec(out_vec)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;
    bit m_loaded = 0, m_closed = 0;
    int bq[DIM];
    int bk[8][DIM];
    int bv[8][DIM];
    int got[DIM];
    int fire_cyc[8];

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // cycle model: readiness and output validity follow from the loaded/closed flags
    task automatic tick();
        if (!m_loaded || m_closed) check(kv_ready == 1'b0, "R9", "kv_ready while closed", int'(kv_ready), 0);
        if (!m_closed)             check(out_valid == 1'b0, "R9", "out_valid before last", int'(out_valid), 0);
        @(posedge clk);
        #2;
        cyc++;
    endtask

    task automatic load_query();
        for (int i = 0; i < DIM; i++) q_vec[i*DW +: DW] = DW'(bq[i]);
        q_load = 1'b1;
        tick();
        q_load   = 1'b0;
        m_loaded = 1;
        m_closed = 0;
        check(kv_ready == 1'b1, "R2", "kv_ready after load", int'(kv_ready), 1);
    endtask

    task automatic send(input int nt, input bit with_last);
        for (int t = 0; t < nt; t++) begin
            for (int i = 0; i < DIM; i++) begin
                k_vec[i*DW +: DW] = DW'(bk[t][i]);
                v_vec[i*DW +: DW] = DW'(bv[t][i]);
            end
            kv_last  = with_last && (t == nt - 1);
            kv_valid = 1'b1;
            for (int w = 0; w < 20 && !kv_ready; w++) tick();
            fire_cyc[t] = cyc;
            tick();
            if (kv_last) m_closed = 1;
        end
        kv_valid = 1'b0;
        kv_last  = 1'b0;
    endtask

    task automatic collect(input int hold);
        int w;
        logic [DIM*DW-1:0] snap;
        w = 0;
        while (!out_valid && w < 400) begin
            tick();
            w++;
        end
        check(out_valid == 1'b1, "R5", "output produced", int'(out_valid), 1);
        snap = out_vec;
        for (int j = 0; j < DIM; j++) got[j] = int'($signed(out_vec[j*DW +: DW]));
        for (int h = 0; h < hold; h++) begin
            tick();
            check(out_valid == 1'b1 && out_vec == snap, "R11", "held output", int'(out_valid), 1);
        end
        out_ready = 1'b1;
        tick();
        out_ready = 1'b0;
        m_loaded = 0;
        m_closed = 0;
    endtask

    function automatic real ref_out(input int nt, input int j);
        real s[8];
        real mx, den, num;
        for (int t = 0; t < nt; t++) begin
            s[t] = 0.0;
            for (int i = 0; i < DIM; i++) s[t] += real'(bq[i] * bk[t][i]) / 65536.0;
        end
        mx = s[0];
        for (int t = 1; t < nt; t++) if (s[t] > mx) mx = s[t];
        den = 0.0;
        num = 0.0;
        for (int t = 0; t < nt; t++) begin
            den += $exp(s[t] - mx);
            num += $exp(s[t] - mx) * real'(bv[t][j]);
        end
        return num / den;
    endfunction

    task automatic cmp_all(input int nt, input string req, input real tol);
        real e, d;
        for (int j = 0; j < DIM; j++) begin
            e = ref_out(nt, j);
            d = real'(got[j]) - e;
            if (d < 0.0) d = -d;
            check(d <= tol, req, "element vs softmax", got[j], $rtoi(e));
        end
    endtask

    // score of token t is target[t] (real); q = 1/16 everywhere, keys vary per lane
    task automatic make_seq(input int nt, input real tgt[8], input int vseed);
        for (int i = 0; i < DIM; i++) bq[i] = 16;
        for (int t = 0; t < nt; t++)
            for (int i = 0; i < DIM; i++) begin
                bk[t][i] = $rtoi(tgt[t] * 256.0) + ((i % 3) - 1) * 20;
                bv[t][i] = ((t * 37 + i * 53 + vseed) % 512) - 256;
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        real tg[8];
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check(kv_ready == 1'b0, "R1", "kv_ready in reset", int'(kv_ready), 0);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // R4: single token, negative and positive values, exact
        tg[0] = 1.5;
        make_seq(1, tg, 5);
        load_query();
        send(1, 1);
        collect(2);
        for (int j = 0; j < DIM; j++) check(got[j] == bv[0][j], "R4", "single token", got[j], bv[0][j]);

        // R5 + R3: rising scores, new maximum each token
        for (int t = 0; t < 6; t++) tg[t] = -1.0 + 0.5 * real'(t);
        make_seq(6, tg, 11);
        load_query();
        send(6, 1);
        for (int t = 1; t < 6; t++)
            check(fire_cyc[t] - fire_cyc[t-1] == 4, "R3", "accept interval", fire_cyc[t] - fire_cyc[t-1], 4);
        collect(2);
        cmp_all(6, "R5", 32.0);

        // R6: falling scores
        for (int t = 0; t < 5; t++) tg[t] = 2.0 - 0.6 * real'(t);
        make_seq(5, tg, 90);
        load_query();
        send(5, 1);
        collect(2);
        cmp_all(5, "R6", 32.0);

        // R7: equal scores
        for (int t = 0; t < 4; t++) tg[t] = 0.75;
        make_seq(4, tg, 200);
        for (int t = 0; t < 4; t++) for (int i = 0; i < DIM; i++) bk[t][i] = 192;
        load_query();
        send(4, 1);
        collect(2);
        cmp_all(4, "R7", 1.0);

        // R8: large gap, dominant token last then first
        tg[0] = 0.0;
        tg[1] = 100.0;
        make_seq(2, tg, 33);
        load_query();
        send(2, 1);
        collect(2);
        for (int j = 0; j < DIM; j++) check(got[j] == bv[1][j], "R8", "dominant last", got[j], bv[1][j]);
        tg[0] = 100.0;
        tg[1] = 0.0;
        make_seq(2, tg, 77);
        load_query();
        send(2, 1);
        collect(2);
        for (int j = 0; j < DIM; j++) check(got[j] == bv[0][j], "R8", "dominant first", got[j], bv[0][j]);

        // R9: pair offered after last is ignored
        for (int t = 0; t < 3; t++) tg[t] = 0.5 * real'(t);
        make_seq(3, tg, 140);
        load_query();
        send(3, 1);
        for (int i = 0; i < DIM; i++) begin
            k_vec[i*DW +: DW] = DW'(4000);
            v_vec[i*DW +: DW] = DW'(-3000);
        end
        kv_valid = 1'b1;
        collect(2);
        kv_valid = 1'b0;
        cmp_all(3, "R9", 32.0);

        // R10: reload mid-sequence discards earlier tokens
        for (int t = 0; t < 3; t++) tg[t] = 3.0;
        make_seq(3, tg, 400);
        load_query();
        send(2, 0);
        tg[0] = -0.5;
        tg[1] = 0.25;
        tg[2] = 0.0;
        make_seq(3, tg, 250);
        load_query();
        send(3, 1);
        collect(2);
        cmp_all(3, "R10", 32.0);

        // R11: long back-pressure on the output
        tg[0] = 0.0;
        make_seq(1, tg, 60);
        load_query();
        send(1, 1);
        collect(8);
        check(out_valid == 1'b0, "R11", "released after ready", int'(out_valid), 0);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule